// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Master with Enable-Held Select

This block is a serial peripheral master that shifts one frame out on MOSI and one frame in from MISO at the same time. Software writes a frame into a one-entry holding register when `tx_ready` is high. Software reads each captured frame from `rx_data` once `rx_valid` is set. The block has no count of frames per transaction. Instead, the active-low select output is tied to the enable input. Select is driven low once the block is enabled and stays low across any number of frames. It is released to high impedance only when enable drops and no frame is in flight.

The intended way to end a transaction is to wait until `busy` is low and then clear `en`. A disable that arrives early is still safe: the frame already on the wire completes before the select output is released. After a release, the select output stays undriven for a programmable number of clock cycles before it can be driven low again. This guarantees that a slave sees a real deassertion between two transactions that follow each other closely. An optional pulse mode drives select high for one serial clock period between consecutive frames. The clock polarity, clock phase and half-period divider are set through static configuration inputs.

Top module: `spi_sel_master`

## Requirements
- R1: While the block is enabled and outside the inter-frame pulse, `nss_oe` is 1 and `nss_o` is 0. Select stays low across consecutive frames for as long as `en` is held.
- R2: No frame count ends a transaction. With `en` still set, select stays low indefinitely after the last frame. Once `en` is 0 and `busy` is 0, `nss_oe` falls on the next clock edge.
- R3: `busy` is 1 from the clock edge that accepts a write until the frame has fully ended, including the half SCLK period after the final SCLK edge.
- R4: If `en` is cleared while `busy` is 1, the frame on the wire completes with correct data. Select stays driven low throughout, and `nss_oe` drops on the same clock edge at which `busy` falls.
- R5: While the block is disabled, `nss_oe` is 0, `tx_ready` is 0, SCLK rests at `cpol`, and a `tx_wr` pulse is ignored: no frame is sent later.
- R6: Each frame sends `tx_data` MSB first on MOSI and returns the frame received on MISO, MSB first, in `rx_data`.
- R7: With `cpha`=0, data is sampled on the SCLK edge that leaves the idle level `cpol`. With `cpha`=1, data is sampled on the edge that returns to it. The other edge changes MOSI. All four modes transfer correctly.
- R8: With `pulse_mode`=1 and a second frame pending, `nss_o` is driven high for 2×H clock cycles between the frames, where H is the half period. It is then low for H+1 cycles before the next frame's first SCLK edge. A lone frame produces no pulse.
- R9: After a release, if `en` is set again at once, `nss_oe` stays 0 for exactly `min_off`+1 clock cycles.
- R10: `rx_valid` rises on the final sampling edge of a frame and is cleared by `rx_rd`. `busy` falls H cycles after `rx_valid` rises when `cpha`=1, and 2×H cycles after when `cpha`=0.
- R11: `tx_ready` is 0 on the cycle after a write is accepted. A `tx_wr` while `tx_ready` is 0 is ignored.
- R12: Each SCLK half period lasts `half_div` clock cycles. A value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Peripheral enable; holds the select |
| pulse_mode | input | 1 | Drive select high between consecutive frames |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | 0: sample on leaving idle; 1: sample on returning |
| half_div | input | DIV_W | SCLK half period in clock cycles (0 acts as 1) |
| min_off | input | GAP_W | Extra undriven cycles required before select is driven again |
| tx_data | input | FRAME_W | Frame to send |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_ready | output | 1 | Holding register can accept a write |
| rx_data | output | FRAME_W | Last received frame |
| rx_valid | output | 1 | rx_data holds an unread frame |
| rx_rd | input | 1 | Clears rx_valid |
| busy | output | 1 | A frame is pending or shifting |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| nss_o | output | 1 | Select level, active low |
| nss_oe | output | 1 | Select output enable; 0 means high impedance |

## Verification
The bench builds the block with an 8-bit frame, a 4-bit divider and a 3-bit gap counter. With this gap width, the release counter saturates well before the first enable, and every `min_off` value can be reached. Half periods of 0, 2 and 3 are used, so the H and 2×H relations between `rx_valid` and `busy`, and the pulse-mode high time, can be told apart from off-by-one errors. A behavioural slave in the bench counts sampling edges to decide the MISO bits and to collect the MOSI bits in all four clock modes. A per-clock monitor checks the select and idle-clock relations on every cycle.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

   typedef enum logic [2:0] {
      ST_OFF,     // select undriven, release counter running
      ST_ON,      // select low, waiting for a frame
      ST_SHIFT,   // SCLK edges in progress
      ST_TAIL,    // half period after the final edge
      ST_GAP      // select high between frames (pulse mode)
   } sel_state_t;

endpackage

// File: rtl/spi_sel_tick.sv
module spi_sel_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   assign lim  = (half_div == '0) ? DIV_W'(1) : half_div;
   assign tick = run && (cnt == lim - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + DIV_W'(1);
   end

endmodule

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl
   import spi_sel_pkg::*;
#(
   parameter int FRAME_W = 8,
   parameter int GAP_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pulse_mode,
   input  logic             cpha,
   input  logic [GAP_W-1:0] min_off,
   input  logic             tick,
   input  logic             buf_full,
   output sel_state_t       state,
   output logic             ph,
   output logic             run,
   output logic             load,
   output logic             do_shift,
   output logic             do_sample,
   output logic             last_sample
);

   localparam int EDGES = 2 * FRAME_W;
   localparam int EC_W  = $clog2(EDGES);
   localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES - 1);

   sel_state_t       nxt;
   logic [EC_W-1:0]  edge_cnt;
   logic [GAP_W-1:0] off_cnt;
   logic             shift_tick;
   logic             leading;
   logic             samp_edge;

   assign run        = (state == ST_SHIFT) || (state == ST_TAIL) || (state == ST_GAP);
   assign load       = (state == ST_ON) && en && buf_full;
   assign shift_tick = (state == ST_SHIFT) && tick;
   assign leading    = ~edge_cnt[0];
   assign samp_edge  = leading ^ cpha;

   assign do_sample   = shift_tick && samp_edge;
   assign do_shift    = shift_tick && !samp_edge
                        && !(!cpha && edge_cnt == LAST_EDGE)
                        && !(cpha && edge_cnt == '0);
   assign last_sample = do_sample && (edge_cnt[EC_W-1:1] == (EC_W-1)'(FRAME_W - 1));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_OFF:   if (en && off_cnt >= min_off) nxt = ST_ON;
         ST_ON:    if (!en) nxt = ST_OFF;
                   else if (buf_full) nxt = ST_SHIFT;
         ST_SHIFT: if (tick && edge_cnt == LAST_EDGE) nxt = ST_TAIL;
         ST_TAIL:  if (tick) begin
                      if (!en)                          nxt = ST_OFF;
                      else if (pulse_mode && buf_full)  nxt = ST_GAP;
                      else                              nxt = ST_ON;
                   end
         ST_GAP:   if (tick && edge_cnt[0]) nxt = ST_ON;
         default:  nxt = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_OFF;
         edge_cnt <= '0;
         ph       <= 1'b0;
         off_cnt  <= '0;
      end else begin
         state <= nxt;
         if (state != ST_OFF)      off_cnt <= '0;
         else if (off_cnt != '1)   off_cnt <= off_cnt + GAP_W'(1);
         if (state == ST_OFF) begin
            ph       <= 1'b0;
            edge_cnt <= '0;
         end else if (shift_tick) begin
            ph       <= ~ph;
            edge_cnt <= (edge_cnt == LAST_EDGE) ? '0 : edge_cnt + EC_W'(1);
         end else if (state == ST_GAP && tick) begin
            edge_cnt <= edge_cnt[0] ? '0 : EC_W'(1);
         end
      end
   end

endmodule

// File: rtl/spi_sel_shift.sv
module spi_sel_shift #(
   parameter int FRAME_W   = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_ok,
   input  logic [FRAME_W-1:0] wr_data,
   input  logic               load,
   input  logic               do_shift,
   input  logic               do_sample,
   input  logic               last_sample,
   input  logic               rd,
   input  logic               miso,
   output logic               buf_full,
   output logic               mosi,
   output logic [FRAME_W-1:0] rx_data,
   output logic               rx_valid
);

   logic [FRAME_W-1:0] hold_q;
   logic [FRAME_W-1:0] tx_sh;
   logic [FRAME_W-1:0] rx_sh;
   logic [FRAME_W-1:0] tx_nxt;
   logic [FRAME_W-1:0] rx_nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign mosi   = tx_sh[FRAME_W-1];
         assign tx_nxt = {tx_sh[FRAME_W-2:0], 1'b0};
         assign rx_nxt = {rx_sh[FRAME_W-2:0], miso};
      end else begin : g_lsb
         assign mosi   = tx_sh[0];
         assign tx_nxt = {1'b0, tx_sh[FRAME_W-1:1]};
         assign rx_nxt = {miso, rx_sh[FRAME_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         hold_q   <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         if (flush || load) buf_full <= 1'b0;
         else if (wr_ok) begin
            buf_full <= 1'b1;
            hold_q   <= wr_data;
         end
         if (load)          tx_sh <= hold_q;
         else if (do_shift) tx_sh <= tx_nxt;
         if (do_sample)     rx_sh <= rx_nxt;
         if (last_sample) begin
            rx_data  <= rx_nxt;
            rx_valid <= 1'b1;
         end else if (rd) begin
            rx_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/spi_sel_master.sv
module spi_sel_master
   import spi_sel_pkg::*;
#(
   parameter int FRAME_W   = 8,
   parameter int DIV_W     = 8,
   parameter int GAP_W     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               pulse_mode,
   input  logic               cpol,
   input  logic               cpha,
   input  logic [DIV_W-1:0]   half_div,
   input  logic [GAP_W-1:0]   min_off,
   input  logic [FRAME_W-1:0] tx_data,
   input  logic               tx_wr,
   output logic               tx_ready,
   output logic [FRAME_W-1:0] rx_data,
   output logic               rx_valid,
   input  logic               rx_rd,
   output logic               busy,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso,
   output logic               nss_o,
   output logic               nss_oe
);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("spi_sel_master: FRAME_W must be 2 or more");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_sel_master: DIV_W must be 1 or more");
      end
      if (GAP_W < 1) begin : g_bad_gap
         $error("spi_sel_master: GAP_W must be 1 or more");
      end
   endgenerate

   sel_state_t state;
   logic ph, run, tick, load, do_shift, do_sample, last_sample, buf_full, live;

   assign live     = (state != ST_OFF);
   assign tx_ready = en && live && !buf_full;
   assign busy     = run || (buf_full && live);
   assign nss_oe   = live;
   assign nss_o    = (state == ST_GAP) || (state == ST_OFF);
   assign sclk     = cpol ^ ph;

   spi_sel_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div), .tick(tick)
   );

   spi_sel_ctrl #(.FRAME_W(FRAME_W), .GAP_W(GAP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .pulse_mode(pulse_mode), .cpha(cpha),
      .min_off(min_off), .tick(tick), .buf_full(buf_full), .state(state),
      .ph(ph), .run(run), .load(load), .do_shift(do_shift),
      .do_sample(do_sample), .last_sample(last_sample)
   );

   spi_sel_shift #(.FRAME_W(FRAME_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .flush(!live), .wr_ok(tx_wr && tx_ready),
      .wr_data(tx_data), .load(load), .do_shift(do_shift),
      .do_sample(do_sample), .last_sample(last_sample), .rd(rx_rd),
      .miso(miso), .buf_full(buf_full), .mosi(mosi), .rx_data(rx_data),
      .rx_valid(rx_valid)
   );

endmodule

// File: rtl/spi_sel_master_chk.sv
module spi_sel_master_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic cpol,
   input logic busy,
   input logic nss_o,
   input logic nss_oe,
   input logic sclk,
   input logic rx_valid,
   input logic tx_ready
);

   AST_SEL_LOW_WHILE_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
      (nss_oe && sclk != cpol) |-> !nss_o); // R1

   AST_RELEASE_ONLY_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nss_oe) |-> !$past(en)); // R2

   AST_BUSY_KEEPS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> nss_oe); // R4

   AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !nss_oe |-> (sclk == cpol)); // R5

   AST_PULSE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (nss_oe && nss_o) |-> (sclk == cpol)); // R8

   AST_RX_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> busy); // R10

   AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (en && nss_oe)); // R11

endmodule

bind spi_sel_master spi_sel_master_chk u_chk (.*);

// File: tb/spi_sel_master_test.sv
`timescale 1ns/1ps
module spi_sel_master_test;

   localparam int FW = 8;
   localparam int DW = 4;
   localparam int GW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0, pulse_mode = 1'b0, cpol = 1'b0, cpha = 1'b0;
   logic [DW-1:0] half_div = 4'd2;
   logic [GW-1:0] min_off = 3'd3;
   logic [FW-1:0] tx_data = '0;
   logic          tx_wr = 1'b0, rx_rd = 1'b0;
   logic          tx_ready, rx_valid, busy, sclk, mosi, miso, nss_o, nss_oe;
   logic [FW-1:0] rx_data;

   int nchk = 0, nbad = 0, mon_bad = 0, samp_cnt = 0;
   bit finished = 1'b0;
   logic [FW-1:0] resp [0:31];
   logic [FW-1:0] got  [0:31];

   always #2.5 clk = ~clk;

   spi_sel_master #(.FRAME_W(FW), .DIV_W(DW), .GAP_W(GW)) uut (
      .clk(clk), .rst_n(rst_n), .en(en), .pulse_mode(pulse_mode), .cpol(cpol),
      .cpha(cpha), .half_div(half_div), .min_off(min_off), .tx_data(tx_data),
      .tx_wr(tx_wr), .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_rd(rx_rd), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso),
      .nss_o(nss_o), .nss_oe(nss_oe)
   );

   // Behavioural slave: counts sampling edges, presents MISO, collects MOSI.
   assign miso = resp[(samp_cnt / FW) % 32][FW-1 - (samp_cnt % FW)];

   always @(sclk) begin
      if (rst_n === 1'b1 && nss_oe === 1'b1 && nss_o === 1'b0 &&
          ((sclk !== cpol) == (cpha == 1'b0))) begin
         got[(samp_cnt / FW) % 32] = {got[(samp_cnt / FW) % 32][FW-2:0], mosi};
         samp_cnt++;
      end
   end

   // Per-clock reference relations.
   always @(negedge clk) begin
      if (rst_n) begin
         if (nss_oe === 1'b0 && sclk !== cpol) mon_bad++;
         if (nss_oe === 1'b1 && !pulse_mode && nss_o !== 1'b0) mon_bad++;
         if (busy === 1'b1 && nss_oe !== 1'b1) mon_bad++;
      end
   end

   function automatic int hval();
      return (half_div == 0) ? 1 : int'(half_div);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 2000 && tx_ready !== 1'b1; i++) @(negedge clk);
   endtask

   task automatic put(input logic [FW-1:0] d);
      wait_ready();
      tx_data = d; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000 && busy !== 1'b0; i++) @(negedge clk);
   endtask

   task automatic enable_on();
      en = 1'b1;
      for (int i = 0; i < 50 && nss_oe !== 1'b1; i++) @(negedge clk);
   endtask

   task automatic disable_off();
      en = 1'b0;
      for (int i = 0; i < 4000 && nss_oe !== 1'b0; i++) @(negedge clk);
      @(negedge clk);
   endtask

   // One frame: checks data both ways and the rx_valid-to-busy spacing.
   task automatic frame(input logic [FW-1:0] d, input string tag);
      int k, n, t_rx, exp_d;
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
      chk(rx_valid === 1'b0, "R10 rx_rd clears valid", rx_valid, 0);
      k = samp_cnt / FW;
      put(d);
      n = 0; t_rx = -1;
      while (n < 4000) begin
         if (rx_valid === 1'b1 && t_rx < 0) t_rx = n;
         if (busy === 1'b0) break;
         @(negedge clk); n++;
      end
      exp_d = cpha ? hval() : 2 * hval();
      chk(got[k % 32] === d, {"R6 R7 mosi ", tag}, got[k % 32], d);
      chk(rx_data === resp[k % 32] && rx_valid === 1'b1, {"R6 R7 miso ", tag},
          rx_data, resp[k % 32]);
      chk(t_rx >= 0 && (n - t_rx) == exp_d, {"R10 R3 busy tail ", tag}, n - t_rx, exp_d);
   endtask

   initial begin
      int n, hi, lo2, k0;
      bit after, seen;
      for (int i = 0; i < 32; i++) begin
         resp[i] = FW'(8'h3C ^ (i * 29 + 7));
         got[i]  = '0;
      end
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      // Reset / disabled state
      chk(nss_oe === 1'b0 && busy === 1'b0 && rx_valid === 1'b0 && tx_ready === 1'b0
          && sclk === 1'b0, "R5 reset state", {nss_oe, busy, rx_valid, tx_ready}, 0);

      // Write while disabled is dropped
      tx_data = 8'h77; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
      cyc(10);
      enable_on();
      cyc(10);
      chk(busy === 1'b0 && samp_cnt == 0, "R5 write while disabled ignored", samp_cnt, 0);
      chk(nss_oe === 1'b1 && nss_o === 1'b0, "R1 select low when enabled", nss_o, 0);

      // Mode 0 single frame
      frame(8'hA7, "mode0");

      // Two frames back to back, select never rises
      k0 = samp_cnt / FW; hi = 0;
      put(8'h5A);
      put(8'hC3);
      for (int i = 0; i < 4000 && busy !== 1'b0; i++) begin
         if (nss_o !== 1'b0 || nss_oe !== 1'b1) hi++;
         @(negedge clk);
      end
      chk(hi == 0, "R1 select held across frames", hi, 0);
      chk(got[k0] === 8'h5A && got[k0+1] === 8'hC3, "R6 back-to-back data", got[k0+1], 8'hC3);

      // No automatic end of transaction
      cyc(40);
      chk(nss_oe === 1'b1 && nss_o === 1'b0, "R2 select held while idle and enabled", nss_oe, 1);

      // Single write is ready-gated and a second strobe while full is dropped
      k0 = samp_cnt / FW;
      tx_data = 8'h11; tx_wr = 1'b1; @(negedge clk);
      chk(tx_ready === 1'b0, "R11 ready low after accepted write", tx_ready, 0);
      tx_data = 8'hEE; @(negedge clk); tx_wr = 1'b0;
      put(8'h22);
      wait_idle();
      cyc(2);
      chk(got[k0] === 8'h11 && got[k0+1] === 8'h22 && samp_cnt == (k0 + 2) * FW,
          "R11 write while full ignored", samp_cnt, (k0 + 2) * FW);

      // Pulse mode with two frames
      pulse_mode = 1'b1;
      k0 = samp_cnt / FW; hi = 0; lo2 = 0; after = 0; seen = 0;
      put(8'h96);
      put(8'h3B);
      for (int i = 0; i < 4000 && busy !== 1'b0; i++) begin
         if (nss_oe === 1'b1 && nss_o === 1'b1) begin hi++; after = 1; end
         else if (after && !seen) begin
            if (sclk === cpol) lo2++; else seen = 1;
         end
         @(negedge clk);
      end
      chk(hi == 2 * hval(), "R8 pulse high time", hi, 2 * hval());
      chk(lo2 == hval() + 1, "R8 low before next edge", lo2, hval() + 1);
      chk(got[k0] === 8'h96 && got[k0+1] === 8'h3B && rx_data === resp[k0+1],
          "R8 pulse mode data", got[k0+1], 8'h3B);
      hi = 0;
      put(8'h44);
      for (int i = 0; i < 4000 && busy !== 1'b0; i++) begin
         if (nss_o !== 1'b0) hi++;
         @(negedge clk);
      end
      chk(hi == 0, "R8 lone frame has no pulse", hi, 0);
      pulse_mode = 1'b0;
      cyc(2);

      // Early disable
      k0 = samp_cnt / FW; hi = 0;
      put(8'hD2);
      cyc(6);
      en = 1'b0;
      for (int i = 0; i < 4000 && busy !== 1'b0; i++) begin
         if (nss_oe !== 1'b1 || nss_o !== 1'b0) hi++;
         @(negedge clk);
      end
      chk(hi == 0, "R4 select held until busy clears", hi, 0);
      chk(nss_oe === 1'b0, "R4 release with busy fall", nss_oe, 0);
      chk(got[k0] === 8'hD2 && rx_data === resp[k0], "R4 frame completes", got[k0], 8'hD2);

      // Minimum undriven time on quick re-enable
      enable_on();
      cyc(3);
      en = 1'b0; @(negedge clk);
      chk(nss_oe === 1'b0, "R2 release one edge after disable", nss_oe, 0);
      en = 1'b1; n = 1;
      for (int i = 0; i < 50 && nss_oe !== 1'b1; i++) begin @(negedge clk); if (nss_oe !== 1'b1) n++; end
      chk(n == int'(min_off) + 1, "R9 undriven gap", n, int'(min_off) + 1);

      // Other clock modes
      for (int m = 1; m < 4; m++) begin
         disable_off();
         cpol = m[1]; cpha = m[0];
         @(negedge clk);
         chk(sclk === cpol, "R5 R7 idle clock level", sclk, cpol);
         enable_on();
         frame(FW'(8'h69 + m * 17), $sformatf("mode%0d", m));
      end

      // Half-period length, including zero treated as one
      for (int j = 0; j < 2; j++) begin
         half_div = (j == 0) ? 4'd3 : 4'd0;
         @(negedge clk);
         put(8'hB4);
         for (int i = 0; i < 200 && sclk === cpol; i++) @(negedge clk);
         n = 0;
         for (int i = 0; i < 200 && sclk !== cpol; i++) begin n++; @(negedge clk); end
         chk(n == ((j == 0) ? 3 : 1), "R12 half period", n, (j == 0) ? 3 : 1);
         wait_idle();
      end

      chk(mon_bad == 0, "R1 R5 per-clock monitor", mon_bad, 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nchk++; nbad++;
         $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

endmodule